// File: doc/BRIEF.md
# Background Memory Patrol Scrubber

The patrol scrubber walks every line of a multi-channel memory in the background. For each line it reads 64 bytes and has the line's ECC checked. A line that comes back with a correctable error is written back, with the corrected data, to the same address before the pointer moves on. A line with an uncorrectable error produces a one-cycle interrupt pulse and is recorded in a sticky log, and the walk then continues.

Reads are paced by a programmable interval. Software derives that interval from the memory size and the desired sweep period, which is usually about a day. Only one channel is scrubbed at a time. On that channel, demand traffic and self-refresh entry both win over starting a scrub read. Once a scrub operation has started, however, the channel cannot enter self-refresh until the operation has finished.

The block talks to the memory controller through four groups of signals:
- a read request/grant pair that carries the current channel and line;
- an ECC status return with the corrected data;
- a writeback request/grant pair with data;
- an error log that software can clear.

Top module: `patrol_scrubber`

## Requirements
- R1: After reset, rd_req, wb_req, ue_irq and ue_log_valid are low, and the scrub address is channel 0, line 0.
- R2: With the channel free, rd_req rises exactly cfg_interval+1 cycles after reset release or after the clock edge that completes the previous line, and never earlier. A line completes on a response without a correctable-only error, or on the writeback grant.
- R3: rd_req stays high, with req_ch and req_line unchanged, until rd_gnt is seen. It drops in the cycle after the grant.
- R4: A response with rsp_ce=1 and rsp_ue=0 raises wb_req in the next cycle. The captured rsp_data appears on wb_data, at the same channel and line. The address advances only after wb_gnt.
- R5: A response with rsp_ue=1 (rsp_ue takes precedence over rsp_ce) gives a one-cycle ue_irq pulse and issues no writeback. It sets ue_log_valid, and the walk continues. While the log is valid, later uncorrectable errors leave the logged channel and line unchanged.
- R6: ue_clr clears ue_log_valid. If an uncorrectable response arrives in the same cycle as ue_clr, the new address is logged and ue_log_valid stays set.
- R7: Each completed line increments req_line. After line 2^LINE_AW-1 the address moves to line 0 of the next channel, and after the last channel it wraps to channel 0.
- R8: No scrub read starts while demand_pending is set for the current channel. Demand on other channels has no effect. Once that bit drops with the interval already elapsed, rd_req rises in the next cycle.
- R9: sr_grant[c] equals sr_req[c], except on the current channel while a scrub operation is in flight (read request, wait for response, or writeback). A self-refresh request on the current channel while the scrubber is idle is granted, and it holds off the next scrub read.
- R10: rd_req and wb_req are never high together.
- R11: A response with neither error flag causes no writeback, and the address advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | CNT_W | Idle cycles required between line completion and the next read |
| demand_pending | input | NUM_CH | Per-channel demand request pending |
| sr_req | input | NUM_CH | Per-channel self-refresh entry request |
| sr_grant | output | NUM_CH | Per-channel self-refresh entry permission |
| rd_req | output | 1 | Scrub read request |
| rd_gnt | input | 1 | Read request accepted |
| req_ch | output | max(1,clog2(NUM_CH)) | Channel of the current scrub line |
| req_line | output | LINE_AW | Line index within the channel |
| rsp_valid | input | 1 | ECC result of the scrub read is valid |
| rsp_ce | input | 1 | Correctable error found |
| rsp_ue | input | 1 | Uncorrectable error found |
| rsp_data | input | DATA_W | Corrected line data |
| wb_req | output | 1 | Corrected-line writeback request |
| wb_gnt | input | 1 | Writeback accepted |
| wb_data | output | DATA_W | Corrected data to write |
| ue_clr | input | 1 | Clear the uncorrectable-error log |
| ue_irq | output | 1 | One-cycle uncorrectable-error interrupt |
| ue_log_valid | output | 1 | Sticky: log holds an address |
| ue_log_ch | output | max(1,clog2(NUM_CH)) | Logged channel |
| ue_log_line | output | LINE_AW | Logged line |

## Verification
The bench builds the block with three channels, four lines per channel, a 6-bit interval counter and a 32-bit data path. Because there are three channels, the channel wrap has to be decoded explicitly rather than falling out of counter overflow. With only twelve lines a full sweep, both channel crossings and the return to channel 0 all occur within a few hundred cycles. The narrow counter allows the interval to be changed between several values, including zero, and the exact read spacing to be measured each time.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WBACK = 2'd3
  } scrub_state_e;

  typedef enum logic [1:0] {
    RSP_CLEAN = 2'd0,
    RSP_FIX   = 2'd1,
    RSP_LOST  = 2'd2
  } rsp_class_e;

  // Uncorrectable dominates correctable.
  function automatic rsp_class_e classify(input logic ce, input logic ue);
    if (ue) return RSP_LOST;
    if (ce) return RSP_FIX;
    return RSP_CLEAN;
  endfunction

endpackage

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] cfg_interval,
  output logic             ready
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] elapsed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  elapsed_q <= '0;
    else if (restart)            elapsed_q <= '0;
    else if (elapsed_q != CNT_MAX) elapsed_q <= elapsed_q + 1'b1;
  end

  assign ready = (elapsed_q >= cfg_interval);

endmodule

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
  parameter int NUM_CH  = 4,
  parameter int LINE_AW = 24,
  parameter int CH_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  output logic [CH_W-1:0]    cur_ch,
  output logic [LINE_AW-1:0] cur_line
);

  localparam logic [LINE_AW-1:0] LAST_LINE = '1;

  logic line_last;
  assign line_last = (cur_line == LAST_LINE);

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_line <= '0;
    else if (advance) cur_line <= line_last ? '0 : cur_line + 1'b1;
  end

  generate
    if (NUM_CH > 1) begin : g_multi
      localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

      function automatic logic [CH_W-1:0] next_ch(input logic [CH_W-1:0] c);
        return (c == LAST_CH) ? '0 : c + 1'b1;
      endfunction

      always_ff @(posedge clk) begin
        if (!rst_n)                    cur_ch <= '0;
        else if (advance && line_last) cur_ch <= next_ch(cur_ch);
      end
    end else begin : g_single
      assign cur_ch = '0;
    end
  endgenerate

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pace_ok,
  input  logic [CH_W-1:0]   cur_ch,
  input  logic [NUM_CH-1:0] demand_pending,
  input  logic [NUM_CH-1:0] sr_req,
  input  logic              rd_gnt,
  input  logic              rsp_valid,
  input  logic              rsp_ce,
  input  logic              rsp_ue,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              wb_gnt,
  output logic              rd_req,
  output logic              wb_req,
  output logic [DATA_W-1:0] wb_data,
  output logic              busy,
  output logic              step_done,
  output logic              ue_hit
);

  scrub_state_e st_q, st_d;
  rsp_class_e   cls;
  logic         ch_free;
  logic         rsp_seen;

  assign cls      = classify(rsp_ce, rsp_ue);
  assign ch_free  = !demand_pending[cur_ch] && !sr_req[cur_ch];
  assign rsp_seen = (st_q == ST_WAIT) && rsp_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (pace_ok && ch_free) st_d = ST_READ;
      ST_READ:  if (rd_gnt)             st_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid)          st_d = (cls == RSP_FIX) ? ST_WBACK : ST_IDLE;
      ST_WBACK: if (wb_gnt)             st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          wb_data <= '0;
    else if (rsp_seen && cls == RSP_FIX) wb_data <= rsp_data;
  end

  assign rd_req    = (st_q == ST_READ);
  assign wb_req    = (st_q == ST_WBACK);
  assign busy      = (st_q != ST_IDLE);
  assign step_done = (rsp_seen && cls != RSP_FIX) || (wb_req && wb_gnt);
  assign ue_hit    = rsp_seen && (cls == RSP_LOST);

endmodule

// File: rtl/scrub_err_log.sv
module scrub_err_log #(
  parameter int CH_W    = 2,
  parameter int LINE_AW = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ue_hit,
  input  logic [CH_W-1:0]    hit_ch,
  input  logic [LINE_AW-1:0] hit_line,
  input  logic               ue_clr,
  output logic               irq,
  output logic               log_valid,
  output logic [CH_W-1:0]    log_ch,
  output logic [LINE_AW-1:0] log_line
);

  logic capture;
  assign capture = ue_hit && (!log_valid || ue_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      log_valid <= 1'b0;
      log_ch    <= '0;
      log_line  <= '0;
    end else begin
      irq <= ue_hit;
      if (capture) begin
        log_valid <= 1'b1;
        log_ch    <= hit_ch;
        log_line  <= hit_line;
      end else if (ue_clr) begin
        log_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/patrol_scrubber.sv
module patrol_scrubber #(
  parameter  int NUM_CH  = 4,
  parameter  int LINE_AW = 24,
  parameter  int CNT_W   = 20,
  parameter  int DATA_W  = 512,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_interval,
  input  logic [NUM_CH-1:0]  demand_pending,
  input  logic [NUM_CH-1:0]  sr_req,
  output logic [NUM_CH-1:0]  sr_grant,
  output logic               rd_req,
  input  logic               rd_gnt,
  output logic [CH_W-1:0]    req_ch,
  output logic [LINE_AW-1:0] req_line,
  input  logic               rsp_valid,
  input  logic               rsp_ce,
  input  logic               rsp_ue,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               wb_req,
  input  logic               wb_gnt,
  output logic [DATA_W-1:0]  wb_data,
  input  logic               ue_clr,
  output logic               ue_irq,
  output logic               ue_log_valid,
  output logic [CH_W-1:0]    ue_log_ch,
  output logic [LINE_AW-1:0] ue_log_line
);

  // Internal events, named for the bound checker.
  logic pace_ok;
  logic scrub_busy;
  logic step_done;
  logic ue_hit;

  scrub_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (step_done),
    .cfg_interval (cfg_interval),
    .ready        (pace_ok)
  );

  scrub_addr_gen #(.NUM_CH(NUM_CH), .LINE_AW(LINE_AW), .CH_W(CH_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (step_done),
    .cur_ch   (req_ch),
    .cur_line (req_line)
  );

  scrub_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .pace_ok        (pace_ok),
    .cur_ch         (req_ch),
    .demand_pending (demand_pending),
    .sr_req         (sr_req),
    .rd_gnt         (rd_gnt),
    .rsp_valid      (rsp_valid),
    .rsp_ce         (rsp_ce),
    .rsp_ue         (rsp_ue),
    .rsp_data       (rsp_data),
    .wb_gnt         (wb_gnt),
    .rd_req         (rd_req),
    .wb_req         (wb_req),
    .wb_data        (wb_data),
    .busy           (scrub_busy),
    .step_done      (step_done),
    .ue_hit         (ue_hit)
  );

  scrub_err_log #(.CH_W(CH_W), .LINE_AW(LINE_AW)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .ue_hit    (ue_hit),
    .hit_ch    (req_ch),
    .hit_line  (req_line),
    .ue_clr    (ue_clr),
    .irq       (ue_irq),
    .log_valid (ue_log_valid),
    .log_ch    (ue_log_ch),
    .log_line  (ue_log_line)
  );

  // Self-refresh is withheld only from the channel with an operation in flight.
  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sr
      assign sr_grant[g] = sr_req[g] && !(scrub_busy && (req_ch == CH_W'(g)));
    end
  endgenerate

endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter  int NUM_CH  = 4,
  parameter  int LINE_AW = 24,
  parameter  int CNT_W   = 20,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   cfg_interval,
  input logic [NUM_CH-1:0]  demand_pending,
  input logic [NUM_CH-1:0]  sr_req,
  input logic [NUM_CH-1:0]  sr_grant,
  input logic               rd_req,
  input logic               rd_gnt,
  input logic [CH_W-1:0]    req_ch,
  input logic [LINE_AW-1:0] req_line,
  input logic               rsp_valid,
  input logic               rsp_ce,
  input logic               rsp_ue,
  input logic               wb_req,
  input logic               wb_gnt,
  input logic               ue_clr,
  input logic               ue_irq,
  input logic               ue_log_valid,
  input logic               scrub_busy,
  input logic               step_done
);

  localparam logic [CH_W-1:0]    LAST_CH   = CH_W'(NUM_CH - 1);
  localparam logic [LINE_AW-1:0] LAST_LINE = '1;
  localparam logic [CNT_W:0]     GAP_MAX   = '1;

  logic waiting, dem_cur, sr_cur, port_done;
  logic [CNT_W:0] gap_q;

  assign waiting   = scrub_busy && !rd_req && !wb_req;
  assign dem_cur   = demand_pending[req_ch];
  assign sr_cur    = sr_req[req_ch];
  assign port_done = (waiting && rsp_valid && (rsp_ue || !rsp_ce)) || (wb_req && wb_gnt);

  // Independent count of cycles since the last line completed, from port activity.
  always_ff @(posedge clk) begin
    if (!rst_n)               gap_q <= '0;
    else if (port_done)       gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !rd_req && !wb_req && !ue_irq && !ue_log_valid);

  assert_pace_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> gap_q >= {1'b0, cfg_interval});

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(req_ch) && $stable(req_line));

  assert_fix_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && rsp_valid && rsp_ce && !rsp_ue |=> wb_req && $stable(req_ch) && $stable(req_line));

  assert_ue_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && rsp_valid && rsp_ue |=> ue_irq && ue_log_valid && !wb_req);

  assert_log_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ue_clr && !(waiting && rsp_valid && rsp_ue) |=> !ue_log_valid);

  assert_line_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_done && req_line != LAST_LINE |=> req_line == $past(req_line) + 1'b1 && $stable(req_ch));

  assert_ch_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_done && req_line == LAST_LINE && req_ch != LAST_CH |=> req_line == '0 && req_ch == $past(req_ch) + 1'b1);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_done && req_line == LAST_LINE && req_ch == LAST_CH |=> req_line == '0 && req_ch == '0);

  assert_demand_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> !$past(dem_cur));

  assert_sr_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> !$past(sr_cur));

  assert_sr_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_busy |-> !sr_grant[req_ch]);

  assert_single_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, wb_req}));

  assert_clean_skip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && rsp_valid && !rsp_ce && !rsp_ue |=> !wb_req);

endmodule

bind patrol_scrubber scrub_checker #(
  .NUM_CH (NUM_CH),
  .LINE_AW(LINE_AW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_interval   (cfg_interval),
  .demand_pending (demand_pending),
  .sr_req         (sr_req),
  .sr_grant       (sr_grant),
  .rd_req         (rd_req),
  .rd_gnt         (rd_gnt),
  .req_ch         (req_ch),
  .req_line       (req_line),
  .rsp_valid      (rsp_valid),
  .rsp_ce         (rsp_ce),
  .rsp_ue         (rsp_ue),
  .wb_req         (wb_req),
  .wb_gnt         (wb_gnt),
  .ue_clr         (ue_clr),
  .ue_irq         (ue_irq),
  .ue_log_valid   (ue_log_valid),
  .scrub_busy     (scrub_busy),
  .step_done      (step_done)
);

// File: tb/sim_patrol_scrubber.sv
module sim_patrol_scrubber;

  localparam int NUM_CH  = 3;
  localparam int LINE_AW = 2;
  localparam int CNT_W   = 6;
  localparam int DATA_W  = 32;
  localparam int CH_W    = 2;
  localparam int LINES   = 4;

  localparam int K_CLEAN = 0;
  localparam int K_CE    = 1;
  localparam int K_UE    = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [CNT_W-1:0]   cfg_interval = '0;
  logic [NUM_CH-1:0]  demand_pending = '0;
  logic [NUM_CH-1:0]  sr_req = '0;
  logic [NUM_CH-1:0]  sr_grant;
  logic               rd_req;
  logic               rd_gnt = 1'b0;
  logic [CH_W-1:0]    req_ch;
  logic [LINE_AW-1:0] req_line;
  logic               rsp_valid = 1'b0;
  logic               rsp_ce = 1'b0;
  logic               rsp_ue = 1'b0;
  logic [DATA_W-1:0]  rsp_data = '0;
  logic               wb_req;
  logic               wb_gnt = 1'b0;
  logic [DATA_W-1:0]  wb_data;
  logic               ue_clr = 1'b0;
  logic               ue_irq;
  logic               ue_log_valid;
  logic [CH_W-1:0]    ue_log_ch;
  logic [LINE_AW-1:0] ue_log_line;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_ch   = 0;
  int exp_line = 0;

  always #10 clk = ~clk;

  patrol_scrubber #(
    .NUM_CH(NUM_CH), .LINE_AW(LINE_AW), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
    .demand_pending(demand_pending), .sr_req(sr_req), .sr_grant(sr_grant),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .req_ch(req_ch), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_ce(rsp_ce), .rsp_ue(rsp_ue), .rsp_data(rsp_data),
    .wb_req(wb_req), .wb_gnt(wb_gnt), .wb_data(wb_data),
    .ue_clr(ue_clr), .ue_irq(ue_irq), .ue_log_valid(ue_log_valid),
    .ue_log_ch(ue_log_ch), .ue_log_line(ue_log_line)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected address order, from R7.
  task automatic adv_exp();
    if (exp_line == LINES - 1) begin
      exp_line = 0;
      exp_ch   = (exp_ch == NUM_CH - 1) ? 0 : exp_ch + 1;
    end else begin
      exp_line = exp_line + 1;
    end
  endtask

  task automatic wait_rd(output int cnt);
    cnt = 0;
    while (!rd_req && cnt < 300) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  // One full scrub step; exp_wait < 0 skips the spacing check.
  task automatic serve(input int kind, input logic [DATA_W-1:0] d,
                       input int exp_wait, input bit clr);
    int w;
    wait_rd(w);
    if (exp_wait >= 0) chk(w == exp_wait, "R2", "read spacing", w, exp_wait);
    chk(rd_req == 1'b1, "R3", "read raised", rd_req, 1);
    chk(req_ch == CH_W'(exp_ch), "R7", "read channel", req_ch, exp_ch);
    chk(req_line == LINE_AW'(exp_line), "R7", "read line", req_line, exp_line);
    @(negedge clk);
    chk(rd_req && req_line == LINE_AW'(exp_line), "R3", "held without grant", rd_req, 1);
    rd_gnt = 1'b1;
    @(negedge clk);
    rd_gnt = 1'b0;
    chk(rd_req == 1'b0, "R3", "drop after grant", rd_req, 0);
    rsp_valid = 1'b1;
    rsp_ce    = (kind == K_CE);
    rsp_ue    = (kind == K_UE);
    rsp_data  = d;
    ue_clr    = clr;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_ce = 1'b0; rsp_ue = 1'b0; ue_clr = 1'b0;
    chk(!(rd_req && wb_req), "R10", "one op at a time", {rd_req, wb_req}, 0);
    if (kind == K_CE) begin
      chk(wb_req == 1'b1, "R4", "writeback raised", wb_req, 1);
      chk(wb_data == d, "R4", "writeback data", wb_data, d);
      chk(req_ch == CH_W'(exp_ch) && req_line == LINE_AW'(exp_line), "R4",
          "writeback address", req_line, exp_line);
      @(negedge clk);
      chk(wb_req == 1'b1 && req_line == LINE_AW'(exp_line), "R4", "held before grant", wb_req, 1);
      wb_gnt = 1'b1;
      @(negedge clk);
      wb_gnt = 1'b0;
      chk(wb_req == 1'b0, "R4", "writeback done", wb_req, 0);
    end else begin
      chk(wb_req == 1'b0, (kind == K_UE) ? "R5" : "R11", "no writeback", wb_req, 0);
      chk(ue_irq == (kind == K_UE), "R5", "interrupt level", ue_irq, kind == K_UE);
    end
    adv_exp();
  endtask

  task automatic t_reset();
    chk(!rd_req && !wb_req, "R1", "requests in reset", {rd_req, wb_req}, 0);
    chk(!ue_irq && !ue_log_valid, "R1", "log in reset", {ue_irq, ue_log_valid}, 0);
    chk(req_ch == '0 && req_line == '0, "R1", "start address", {req_ch, req_line}, 0);
  endtask

  task automatic t_pacing();
    for (int i = 0; i < 4; i++) serve(K_CLEAN, '0, 6, 1'b0);
    cfg_interval = 6'd2;
    serve(K_CLEAN, '0, 3, 1'b0);
    cfg_interval = 6'd0;
    serve(K_CLEAN, '0, 1, 1'b0);
    cfg_interval = 6'd3;
  endtask

  task automatic t_correctable();
    serve(K_CE, 32'hA5A5_0F0F, 4, 1'b0);
    serve(K_CE, 32'h1234_5678, 4, 1'b0);
  endtask

  task automatic t_uncorrectable();
    int first_ch, first_line;
    first_ch = exp_ch; first_line = exp_line;
    serve(K_UE, '0, 4, 1'b0);
    chk(ue_log_valid == 1'b1, "R5", "log set", ue_log_valid, 1);
    chk(ue_log_ch == CH_W'(first_ch) && ue_log_line == LINE_AW'(first_line), "R5",
        "logged line", ue_log_line, first_line);
    @(negedge clk);
    chk(ue_irq == 1'b0, "R5", "interrupt is a pulse", ue_irq, 0);
    serve(K_UE, '0, -1, 1'b0);
    chk(ue_log_line == LINE_AW'(first_line) && ue_log_ch == CH_W'(first_ch), "R5",
        "sticky first address", ue_log_line, first_line);
    first_ch = exp_ch; first_line = exp_line;
    serve(K_UE, '0, -1, 1'b1);
    chk(ue_log_valid && ue_log_line == LINE_AW'(first_line) && ue_log_ch == CH_W'(first_ch),
        "R6", "clear with new error logs it", ue_log_line, first_line);
    ue_clr = 1'b1;
    @(negedge clk);
    ue_clr = 1'b0;
    chk(ue_log_valid == 1'b0, "R6", "clear empties log", ue_log_valid, 0);
  endtask

  task automatic t_demand();
    bit quiet;
    cfg_interval = 6'd2;
    demand_pending = '1;
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rd_req) quiet = 1'b0;
    end
    chk(quiet, "R8", "no read under demand", !quiet, 0);
    demand_pending = ~(NUM_CH'(1) << exp_ch);
    @(negedge clk);
    chk(rd_req == 1'b1, "R8", "read right after demand drops", rd_req, 1);
    serve(K_CLEAN, '0, 0, 1'b0);
    demand_pending = '0;
  endtask

  task automatic t_self_refresh();
    bit quiet;
    int w;
    sr_req = NUM_CH'(1) << exp_ch;
    #1;
    chk(sr_grant == sr_req, "R9", "idle channel granted", sr_grant, sr_req);
    quiet = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rd_req) quiet = 1'b0;
    end
    chk(quiet, "R9", "self-refresh holds off scrub", !quiet, 0);
    sr_req = '0;
    @(negedge clk);
    chk(rd_req == 1'b1, "R9", "read after release", rd_req, 1);
    serve(K_CLEAN, '0, 0, 1'b0);
    // In flight: the current channel must be refused.
    wait_rd(w);
    sr_req = '1;
    #1;
    chk(sr_grant == (~(NUM_CH'(1) << exp_ch) & '1), "R9", "blocked while reading",
        sr_grant, ~(NUM_CH'(1) << exp_ch) & 3'b111);
    @(negedge clk);
    rd_gnt = 1'b1;
    @(negedge clk);
    rd_gnt = 1'b0;
    chk(sr_grant == (~(NUM_CH'(1) << exp_ch) & '1), "R9", "blocked while waiting",
        sr_grant, ~(NUM_CH'(1) << exp_ch) & 3'b111);
    rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(sr_grant == '1, "R9", "granted after completion", sr_grant, 3'b111);
    chk(wb_req == 1'b0, "R11", "clean line no writeback", wb_req, 0);
    sr_req = '0;
    adv_exp();
  endtask

  task automatic t_wrap();
    cfg_interval = 6'd0;
    for (int i = 0; i < 13; i++) serve(K_CLEAN, '0, -1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    cfg_interval = 6'd5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_pacing();
    t_correctable();
    t_uncorrectable();
    t_demand();
    t_self_refresh();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule